// File: doc/BRIEF.md
# Lane Code-Group and Frame Synchronizer

This block sits at the receive end of one serial converter lane, after the 8b/10b decoder and the word aligner. Each link clock it takes one 32-bit word of four decoded octets. Each octet comes with a control-character flag and an error flag. From this stream it controls the active-low synchronization request sent back to the transmitter. While the request is held low, the block hunts for a run of comma characters. It releases the request once the run is long enough. It declares code-group lock after a further run of clean characters.

Once locked, the first non-comma character moves the lane into its data (frame) state. The block records which byte position of the word carried that character. After that it follows the multiframe markers of the initial lane alignment sequence. From the second multiframe it stores the fourteen link-configuration octets into four 32-bit words for the link layer to read.

The four octets of a word are handled in sequence within one clock, lowest byte lane first. A run may therefore start at any byte position and may span word boundaries. All outputs are registered and change on the clock edge after the word that caused the change.

Top module: `lane_sync_rx`

## Requirements
- R1: While reset is low and on the first cycles after it, the outputs are as follows. `sync_req_n` is 0. `cgs_locked`, `frame_data`, `first_data_pos` and `cfg_ready` are 0. `cfg_octets` is all zero.
- R2: An octet is a comma only if its value is 0xBC and its control flag is set. The value 0xBC without the flag counts as ordinary data. Byte lane i of `lane_word` is bits [8i+7:8i], with flag bits `lane_k[i]` and `lane_err[i]`.
- R3: While hunting, four successive error-free commas release the request: `sync_req_n` goes to 1 after the clock edge of the word that holds the fourth comma. The octets are counted in order byte 0 to byte 3, and the count carries across words.
- R4: While hunting, any octet that is not a comma, or that carries an error flag, restarts the comma count at zero.
- R5: After release, four further octets without error flags set `cgs_locked`. These may be any characters, commas included. Lock is reported after the edge of the word that holds the fourth such octet.
- R6: An octet with an error flag received after release and before lock returns the block to hunting, which drives `sync_req_n` back to 0.
- R7: Once locked, error flags have no effect. `sync_req_n` and `cgs_locked` stay at 1 until reset.
- R8: The first non-comma octet processed while locked sets `frame_data`. In the same edge, `first_data_pos` takes that octet's byte index (0 to 3). Both then hold until reset.
- R9: In the data state, control octet 0x1C opens a multiframe and control octet 0x7C closes it. A 0x1C inside an open multiframe is ignored. Capture starts only when control octet 0x9C directly follows the 0x1C that opened the second multiframe. A 0x9C in any other multiframe is ignored.
- R10: The 14 octets that follow that 0x9C are stored with octet j at `cfg_octets[8j+7:8j]`. Bits [127:112] stay zero. `cfg_ready` rises after the edge of the word holding the 14th octet, and later octets leave `cfg_octets` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Link clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lane_word | input | 32 | Four decoded octets, byte 0 first in time |
| lane_k | input | 4 | Control-character flag per octet |
| lane_err | input | 4 | Decode error (disparity or not-in-table) per octet |
| sync_req_n | output | 1 | Synchronization request, low while hunting |
| cgs_locked | output | 1 | Code-group lock reached |
| frame_data | output | 1 | Lane in data state |
| first_data_pos | output | 2 | Byte index of the first non-comma octet after lock |
| cfg_ready | output | 1 | All configuration octets captured |
| cfg_octets | output | 128 | Captured configuration octets, four 32-bit words |

## Verification
The hardest states to reach are those that depend on where a run falls inside a word. One case is a comma run that starts at byte 2 and completes partway through the next word. Another is an error that lands inside the four-character window after release. The stimulus places commas, plain 0xBC data and error flags at chosen byte positions, and sets the expected request and lock state for each word.

Capture of the configuration octets depends on the multiframe count. To exercise it, a byte-level stream is packed into words. The stream puts a decoy 0x9C in the first multiframe and surplus octets after the fourteenth. The result shows whether only the second multiframe was stored.

// File: rtl/lsync_pkg.sv
package lsync_pkg;

  typedef logic [7:0] octet_t;

  typedef enum logic [1:0] {
    CGS_HUNT  = 2'd0,
    CGS_CHECK = 2'd1,
    CGS_LOCK  = 2'd2
  } cgs_state_e;

  localparam octet_t CODE_COMMA   = 8'hBC;
  localparam octet_t CODE_MFSTART = 8'h1C;
  localparam octet_t CODE_MFEND   = 8'h7C;
  localparam octet_t CODE_CFGMARK = 8'h9C;

  function automatic logic is_code(input octet_t o, input logic k, input octet_t code);
    return k && (o == code);
  endfunction

  function automatic octet_t octet_at(input logic [31:0] w, input int idx);
    return w[8*idx +: 8];
  endfunction

endpackage

// File: rtl/lsync_octet_class.sv
module lsync_octet_class
  import lsync_pkg::*;
#(
  parameter int NOCT = 4
) (
  input  logic [8*NOCT-1:0] word_i,
  input  logic [NOCT-1:0]   k_i,
  output logic [NOCT-1:0]   comma_o,
  output logic [NOCT-1:0]   mfstart_o,
  output logic [NOCT-1:0]   mfend_o,
  output logic [NOCT-1:0]   cfgmark_o
);

  for (genvar g = 0; g < NOCT; g++) begin : g_lane
    octet_t oct;
    assign oct          = word_i[8*g +: 8];
    assign comma_o[g]   = is_code(oct, k_i[g], CODE_COMMA);
    assign mfstart_o[g] = is_code(oct, k_i[g], CODE_MFSTART);
    assign mfend_o[g]   = is_code(oct, k_i[g], CODE_MFEND);
    assign cfgmark_o[g] = is_code(oct, k_i[g], CODE_CFGMARK);
  end

endmodule

// File: rtl/lsync_cgs_fsm.sv
module lsync_cgs_fsm
  import lsync_pkg::*;
#(
  parameter int NOCT    = 4,
  parameter int K_REL   = 4,
  parameter int K_LOCK  = 4,
  localparam int CNT_W  = $clog2((K_REL > K_LOCK ? K_REL : K_LOCK) + 1),
  localparam int POS_W  = (NOCT > 1) ? $clog2(NOCT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NOCT-1:0]  comma_i,
  input  logic [NOCT-1:0]  err_i,
  output logic             sync_n_o,
  output logic             locked_o,
  output logic             fs_o,
  output logic [POS_W-1:0] pos_o,
  output logic [NOCT-1:0]  fs_mask_o,
  output logic             release_evt_o,
  output logic             drop_evt_o
);

  cgs_state_e       st_q, st_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic             fs_q, fs_n;
  logic [POS_W-1:0] pos_q, pos_n;

  always_comb begin
    st_n          = st_q;
    cnt_n         = cnt_q;
    fs_n          = fs_q;
    pos_n         = pos_q;
    fs_mask_o     = '0;
    release_evt_o = 1'b0;
    drop_evt_o    = 1'b0;
    for (int i = 0; i < NOCT; i++) begin
      unique case (st_n)
        CGS_HUNT: begin
          if (err_i[i] || !comma_i[i]) begin
            cnt_n = '0;
          end else if (cnt_n == CNT_W'(K_REL - 1)) begin
            st_n          = CGS_CHECK;
            cnt_n         = '0;
            release_evt_o = 1'b1;
          end else begin
            cnt_n = cnt_n + CNT_W'(1);
          end
        end
        CGS_CHECK: begin
          if (err_i[i]) begin
            st_n       = CGS_HUNT;
            cnt_n      = '0;
            drop_evt_o = 1'b1;
          end else if (cnt_n == CNT_W'(K_LOCK - 1)) begin
            st_n  = CGS_LOCK;
            cnt_n = '0;
          end else begin
            cnt_n = cnt_n + CNT_W'(1);
          end
        end
        default: ;
      endcase
      if (st_n == CGS_LOCK && !fs_n && !comma_i[i]) begin
        fs_n  = 1'b1;
        pos_n = POS_W'(i);
      end
      fs_mask_o[i] = fs_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= CGS_HUNT;
      cnt_q <= '0;
      fs_q  <= 1'b0;
      pos_q <= '0;
    end else begin
      st_q  <= st_n;
      cnt_q <= cnt_n;
      fs_q  <= fs_n;
      pos_q <= pos_n;
    end
  end

  assign sync_n_o = (st_q != CGS_HUNT);
  assign locked_o = (st_q == CGS_LOCK);
  assign fs_o     = fs_q;
  assign pos_o    = pos_q;

endmodule

// File: rtl/lsync_cfg_capture.sv
module lsync_cfg_capture
  import lsync_pkg::*;
#(
  parameter int NOCT       = 4,
  parameter int CFG_OCTETS = 14,
  parameter int CFG_REGS   = 4,
  parameter int CFG_MF     = 2,
  localparam int CFG_W     = 32 * CFG_REGS,
  localparam int IDX_W     = $clog2(CFG_OCTETS + 1),
  localparam int MF_W      = $clog2(CFG_MF + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8*NOCT-1:0] word_i,
  input  logic [NOCT-1:0]   fs_mask_i,
  input  logic [NOCT-1:0]   mfstart_i,
  input  logic [NOCT-1:0]   mfend_i,
  input  logic [NOCT-1:0]   cfgmark_i,
  output logic              ready_o,
  output logic [CFG_W-1:0]  cfg_o,
  output logic              start_evt_o,
  output logic              done_evt_o
);

  logic [MF_W-1:0]  mf_q, mf_n;
  logic             open_q, open_n;
  logic             prevr_q, prevr_n;
  logic             act_q, act_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic             rdy_q, rdy_n;
  logic [CFG_W-1:0] cfg_q, cfg_n;
  logic             opened;

  always_comb begin
    mf_n        = mf_q;
    open_n      = open_q;
    prevr_n     = prevr_q;
    act_n       = act_q;
    idx_n       = idx_q;
    rdy_n       = rdy_q;
    cfg_n       = cfg_q;
    start_evt_o = 1'b0;
    done_evt_o  = 1'b0;
    opened      = 1'b0;
    for (int i = 0; i < NOCT; i++) begin
      opened = 1'b0;
      if (fs_mask_i[i]) begin
        if (act_n) begin
          cfg_n[8*int'(idx_n) +: 8] = octet_at(word_i, i);
          if (idx_n == IDX_W'(CFG_OCTETS - 1)) begin
            act_n      = 1'b0;
            rdy_n      = 1'b1;
            done_evt_o = 1'b1;
          end
          idx_n = idx_n + IDX_W'(1);
        end else if (mfstart_i[i]) begin
          if (!open_n) begin
            open_n = 1'b1;
            opened = 1'b1;
            if (mf_n != MF_W'(CFG_MF + 1)) mf_n = mf_n + MF_W'(1);
          end
        end else if (mfend_i[i]) begin
          open_n = 1'b0;
        end else if (cfgmark_i[i] && prevr_n && !rdy_n &&
                     mf_n == MF_W'(CFG_MF)) begin
          act_n       = 1'b1;
          idx_n       = '0;
          start_evt_o = 1'b1;
        end
        prevr_n = opened;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mf_q    <= '0;
      open_q  <= 1'b0;
      prevr_q <= 1'b0;
      act_q   <= 1'b0;
      idx_q   <= '0;
      rdy_q   <= 1'b0;
      cfg_q   <= '0;
    end else begin
      mf_q    <= mf_n;
      open_q  <= open_n;
      prevr_q <= prevr_n;
      act_q   <= act_n;
      idx_q   <= idx_n;
      rdy_q   <= rdy_n;
      cfg_q   <= cfg_n;
    end
  end

  assign ready_o = rdy_q;
  assign cfg_o   = cfg_q;

endmodule

// File: rtl/lane_sync_rx.sv
module lane_sync_rx #(
  parameter int NOCT       = 4,
  parameter int K_REL      = 4,
  parameter int K_LOCK     = 4,
  parameter int CFG_OCTETS = 14,
  parameter int CFG_REGS   = 4,
  parameter int CFG_MF     = 2,
  localparam int WORD_W    = 8 * NOCT,
  localparam int POS_W     = (NOCT > 1) ? $clog2(NOCT) : 1,
  localparam int CFG_W     = 32 * CFG_REGS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] lane_word,
  input  logic [NOCT-1:0]   lane_k,
  input  logic [NOCT-1:0]   lane_err,
  output logic              sync_req_n,
  output logic              cgs_locked,
  output logic              frame_data,
  output logic [POS_W-1:0]  first_data_pos,
  output logic              cfg_ready,
  output logic [CFG_W-1:0]  cfg_octets
);

  logic [NOCT-1:0] comma, mfstart, mfend, cfgmark, fs_mask;
  logic            release_evt, drop_evt, cap_start_evt, cap_done_evt;

  lsync_octet_class #(.NOCT(NOCT)) u_class (
    .word_i    (lane_word),
    .k_i       (lane_k),
    .comma_o   (comma),
    .mfstart_o (mfstart),
    .mfend_o   (mfend),
    .cfgmark_o (cfgmark)
  );

  lsync_cgs_fsm #(.NOCT(NOCT), .K_REL(K_REL), .K_LOCK(K_LOCK)) u_cgs (
    .clk           (clk),
    .rst_n         (rst_n),
    .comma_i       (comma),
    .err_i         (lane_err),
    .sync_n_o      (sync_req_n),
    .locked_o      (cgs_locked),
    .fs_o          (frame_data),
    .pos_o         (first_data_pos),
    .fs_mask_o     (fs_mask),
    .release_evt_o (release_evt),
    .drop_evt_o    (drop_evt)
  );

  lsync_cfg_capture #(
    .NOCT(NOCT), .CFG_OCTETS(CFG_OCTETS), .CFG_REGS(CFG_REGS), .CFG_MF(CFG_MF)
  ) u_cap (
    .clk         (clk),
    .rst_n       (rst_n),
    .word_i      (lane_word),
    .fs_mask_i   (fs_mask),
    .mfstart_i   (mfstart),
    .mfend_i     (mfend),
    .cfgmark_i   (cfgmark),
    .ready_o     (cfg_ready),
    .cfg_o       (cfg_octets),
    .start_evt_o (cap_start_evt),
    .done_evt_o  (cap_done_evt)
  );

endmodule

// File: rtl/lane_sync_rx_chk.sv
module lane_sync_rx_chk #(
  parameter int CFG_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_req_n,
  input logic             cgs_locked,
  input logic             frame_data,
  input logic             cfg_ready,
  input logic [CFG_W-1:0] cfg_octets,
  input logic             release_evt,
  input logic             drop_evt,
  input logic             cap_start_evt,
  input logic             cap_done_evt
);

  // R3
  release_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_req_n) |-> $past(release_evt));

  // R5
  lock_needs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cgs_locked |-> sync_req_n);

  // R6
  drop_to_hunt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> !sync_req_n && !cgs_locked);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cgs_locked |=> cgs_locked && sync_req_n);

  // R8
  data_after_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_data |-> cgs_locked);

  // R9
  capture_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_start_evt |-> frame_data && !cfg_ready);

  // R10
  done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_done_evt |=> cfg_ready);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ready |=> cfg_ready && $stable(cfg_octets));

endmodule

bind lane_sync_rx lane_sync_rx_chk #(.CFG_W(CFG_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .sync_req_n    (sync_req_n),
  .cgs_locked    (cgs_locked),
  .frame_data    (frame_data),
  .cfg_ready     (cfg_ready),
  .cfg_octets    (cfg_octets),
  .release_evt   (release_evt),
  .drop_evt      (drop_evt),
  .cap_start_evt (cap_start_evt),
  .cap_done_evt  (cap_done_evt)
);

// File: tb/lane_sync_rx_test.sv
module lane_sync_rx_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [31:0]  lane_word = '0;
  logic [3:0]   lane_k = '0;
  logic [3:0]   lane_err = '0;
  logic         sync_req_n, cgs_locked, frame_data, cfg_ready;
  logic [1:0]   first_data_pos;
  logic [127:0] cfg_octets;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lane_sync_rx uut (
    .clk(clk), .rst_n(rst_n), .lane_word(lane_word), .lane_k(lane_k),
    .lane_err(lane_err), .sync_req_n(sync_req_n), .cgs_locked(cgs_locked),
    .frame_data(frame_data), .first_data_pos(first_data_pos),
    .cfg_ready(cfg_ready), .cfg_octets(cfg_octets)
  );

  // {word, k, err, exp sync_req_n, exp cgs_locked, exp frame_data}
  localparam int NV = 8;
  localparam logic [42:0] VEC [NV] = '{
    {32'h00BCBCBC, 4'b0111, 4'b0000, 1'b0, 1'b0, 1'b0}, // R4 data breaks run
    {32'hBCBCBCBC, 4'b1111, 4'b1000, 1'b0, 1'b0, 1'b0}, // R4 errored 4th comma
    {32'hBCBCBCBC, 4'b0111, 4'b0000, 1'b0, 1'b0, 1'b0}, // R2 0xBC without flag
    {32'hBCBC0000, 4'b1100, 4'b0000, 1'b0, 1'b0, 1'b0}, // R3 run starts at byte 2
    {32'hBCBCBCBC, 4'b1111, 4'b0000, 1'b1, 1'b0, 1'b0}, // R3 release mid-word
    {32'hBCBCBCBC, 4'b1111, 4'b0000, 1'b1, 1'b1, 1'b0}, // R5 lock, no data yet
    {32'h000000BC, 4'b0001, 4'b0000, 1'b1, 1'b1, 1'b1}, // R8 data at byte 1
    {32'hFFFFFFFF, 4'b0000, 4'b1111, 1'b1, 1'b1, 1'b1}  // R7 errors ignored
  };

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w, input logic [3:0] k, input logic [3:0] e);
    lane_word = w;
    lane_k    = k;
    lane_err  = e;
    @(negedge clk);
  endtask

  task automatic do_reset();
    lane_word = '0; lane_k = '0; lane_err = '0;
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  logic [7:0] pb_d [4];
  logic       pb_k [4];
  int         pb_n = 0;

  task automatic push(input logic [7:0] d, input logic k);
    pb_d[pb_n] = d;
    pb_k[pb_n] = k;
    pb_n++;
    if (pb_n == 4) begin
      apply({pb_d[3], pb_d[2], pb_d[1], pb_d[0]},
            {pb_k[3], pb_k[2], pb_k[1], pb_k[0]}, 4'b0000);
      pb_n = 0;
    end
  endtask

  function automatic logic [7:0] cfg_byte(input int j);
    return 8'(8'h31 + j * 13);
  endfunction

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [127:0] exp_cfg;
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 sync_req_n", 128'(sync_req_n), 128'd0);
    check("R1 cgs_locked", 128'(cgs_locked), 128'd0);
    check("R1 frame_data", 128'(frame_data), 128'd0);
    check("R1 cfg_ready", 128'(cfg_ready), 128'd0);
    check("R1 cfg_octets", cfg_octets, 128'd0);

    // table walk: R2 R3 R4 R5 R7 R8
    for (int v = 0; v < NV; v++) begin
      apply(VEC[v][42:11], VEC[v][10:7], VEC[v][6:3]);
      check($sformatf("R2/R3/R4 step %0d sync", v), 128'(sync_req_n), 128'(VEC[v][2]));
      check($sformatf("R5/R7 step %0d lock", v), 128'(cgs_locked), 128'(VEC[v][1]));
      check($sformatf("R8 step %0d frame", v), 128'(frame_data), 128'(VEC[v][0]));
    end
    check("R8 first_data_pos", 128'(first_data_pos), 128'd1);

    // R6 error inside the lock window
    do_reset();
    apply(32'hBCBCBCBC, 4'hF, 4'h0);
    check("R6 released", 128'(sync_req_n), 128'd1);
    apply(32'hBCBCBCBC, 4'hF, 4'b0100);
    check("R6 back to hunt", 128'(sync_req_n), 128'd0);
    check("R6 not locked", 128'(cgs_locked), 128'd0);

    // R9 R10 alignment sequence capture
    do_reset();
    for (int i = 0; i < 8; i++) push(8'hBC, 1'b1);
    check("R5 locked before sequence", 128'(cgs_locked), 128'd1);
    push(8'hBC, 1'b1); push(8'hBC, 1'b1);
    push(8'h1C, 1'b1);                   // first multiframe opens
    push(8'h9C, 1'b1);                   // decoy marker, must be ignored
    check("R8 frame_data on start marker", 128'(frame_data), 128'd1);
    check("R8 pos of start marker", 128'(first_data_pos), 128'd2);
    for (int i = 0; i < 6; i++) push(8'hEE, 1'b0);
    push(8'h7C, 1'b1);
    push(8'h1C, 1'b1);                   // second multiframe
    push(8'h9C, 1'b1);
    for (int j = 0; j < 14; j++) push(cfg_byte(j), 1'b0);
    push(8'h55, 1'b0); push(8'h55, 1'b0);
    push(8'h7C, 1'b1);
    push(8'h1C, 1'b1); push(8'h11, 1'b0); push(8'h7C, 1'b1);
    push(8'h00, 1'b0); push(8'h00, 1'b0); push(8'h00, 1'b0);
    exp_cfg = '0;
    for (int j = 0; j < 14; j++) exp_cfg[8*j +: 8] = cfg_byte(j);
    check("R9 cfg_ready", 128'(cfg_ready), 128'd1);
    check("R10 cfg_octets", cfg_octets, exp_cfg);

    // R7 errors after lock, R10 later octets do not disturb capture
    apply(32'h9C1C9C1C, 4'hF, 4'hF);
    check("R7 sync held", 128'(sync_req_n), 128'd1);
    check("R7 lock held", 128'(cgs_locked), 128'd1);
    check("R10 cfg unchanged", cfg_octets, exp_cfg);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule